// File: doc/BRIEF.md
# Timer counter with compare outputs

A prescaled up-counter (up to 16 bits) with up to three output-compare channels. A byte-wide register write port sets the clock select, the waveform mode, the compare values, an auxiliary capture value and the count itself. The clock select picks one entry of a prescaler shift table that is supplied on an input port. Each prescaled tick advances the counter toward a TOP value that the waveform mode selects. Reaching TOP raises an overflow flag. A channel whose compare value is reached raises its own flag and acts on its output pin.

Control runs on a two-state machine. `ST_HALT` holds the counter. `ST_RUN` advances it on prescaled ticks. The transition HALT→RUN happens on a control write that changes the select or the mode and leaves the select nonzero. RUN→HALT happens on such a write with the select zero. A changing control write that keeps the state (RUN→RUN or HALT→HALT) is a restart: it clears the count and the prescaler phase. Flags are cleared by writing ones to a flag-clear address.

Address map: 0 control (select in bits 2:0, mode in bits 5:3, bits 7:6 ignored), 1 pin modes, 2/3 count low/high, 4/5, 6/7, 8/9 compare of channel 0/1/2 low/high, 10/11 capture low/high, 12 flag clear.

Top module: `tmr_cmp_top`

## Requirements
- R1: After reset the count, the overflow flag, all channel flags, all pins and all pin drive enables are 0, and the machine is in ST_HALT.
- R2: With select 0 the count holds. Select s in 1..7 advances the count once every 2^k clocks, where k is entry s-1 of the shift table (4-bit entries, entry 0 in the low bits). The first advance comes 2^k clocks after the restart.
- R3: TOP by mode code: 1 gives 255; 2 and 3 give the channel 0 compare value; 4 gives the capture value; 0 and 5..7 give the all-ones count.
- R4: On a tick the count becomes 0 if it was at or above TOP, and otherwise it becomes count+1.
- R5: A tick whose new count equals TOP sets the overflow flag in the same clock.
- R6: A channel matches on a tick whose new count equals its compare value, only when that value is nonzero and no greater than TOP. A match sets the channel's flag.
- R7: Channel n's pin mode is bits 2n+1:2n of address 1. On a match, mode 0 leaves the pin alone, 1 toggles it, 2 clears it and 3 sets it. The drive enable of a pin is high whenever its mode is nonzero.
- R8: A control write that leaves the select and the mode unchanged does not disturb counting. A write that changes either clears the count and the prescaler phase.
- R9: A write to an odd address from 3 to 11 only latches a shared high byte. The following low-byte write commits {latched high, low} to the matching 16-bit register.
- R10: A low-byte count write loads the counter directly in that clock, with no tick or flag evaluated for it. Counting continues from the loaded value.
- R11: A write to address 12 clears the overflow flag where bit 0 is 1, and channel n's flag where bit n+1 is 1. A flag set in the same clock wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write byte |
| psc_tbl | input | 7*SH_W | Prescaler shift per nonzero select |
| count | output | CNT_W | Current count |
| ovf_flag | output | 1 | Overflow (TOP reached) flag |
| cmp_flag | output | NCH | Per-channel compare-match flag |
| oc_pin | output | NCH | Compare output pin level |
| oc_drive | output | NCH | Pin drive enable (mode nonzero) |

## Verification
The assertions assume that the prescaler shift table stays constant while the counter runs, and that every entry is no larger than the prescaler width. They also assume at most one register write per clock through the single port, so that a restart and a count load never coincide. The stimulus holds the table at one fixed value for the whole run. It issues only single-cycle writes. Random traffic keeps compare and capture values small, so matches and short TOP periods occur often, and it sometimes loads the count near all-ones so that the full-width wrap is reached.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        WM_NORMAL  = 3'd0,
        WM_FAST8   = 3'd1,
        WM_CTC     = 3'd2,
        WM_PWM_A   = 3'd3,
        WM_PWM_CAP = 3'd4,
        WM_RSV5    = 3'd5,
        WM_RSV6    = 3'd6,
        WM_RSV7    = 3'd7
    } wave_mode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_CLEAR  = 2'd2,
        OM_SET    = 2'd3
    } out_mode_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam int ADR_W = 4;
    localparam int REG_W = 16;

    localparam logic [ADR_W-1:0] ADR_CTRL     = 4'd0;
    localparam logic [ADR_W-1:0] ADR_OMODE    = 4'd1;
    localparam logic [ADR_W-1:0] ADR_CNT_LO   = 4'd2;
    localparam logic [ADR_W-1:0] ADR_CNT_HI   = 4'd3;
    localparam logic [ADR_W-1:0] ADR_CMP_BASE = 4'd4;
    localparam logic [ADR_W-1:0] ADR_CAP_LO   = 4'd10;
    localparam logic [ADR_W-1:0] ADR_CAP_HI   = 4'd11;
    localparam logic [ADR_W-1:0] ADR_FCLR     = 4'd12;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADR_W-1:0]            wr_addr,
    input  logic [7:0]                  wr_data,
    output logic [2:0]                  cs_q,
    output wave_mode_e                  mode_q,
    output logic [2*NCH-1:0]            om_q,
    output logic [NCH-1:0][REG_W-1:0]   cmp_q,
    output logic [REG_W-1:0]            cap_q,
    output logic                        restart,
    output logic [2:0]                  cs_new,
    output logic                        cnt_load,
    output logic [REG_W-1:0]            load_val,
    output logic                        fclr_ovf,
    output logic [NCH-1:0]              fclr_cmp
);

    logic [7:0] hi_q;
    logic       ctrl_wr;
    logic       hi_wr;

    assign ctrl_wr  = wr_en && (wr_addr == ADR_CTRL);
    assign hi_wr    = wr_en && wr_addr[0] && (wr_addr >= ADR_CNT_HI) && (wr_addr <= ADR_CAP_HI);
    assign cs_new   = wr_data[2:0];
    assign restart  = ctrl_wr && ((wr_data[2:0] != cs_q) || (wr_data[5:3] != mode_q));
    assign cnt_load = wr_en && (wr_addr == ADR_CNT_LO);
    assign load_val = {hi_q, wr_data};
    assign fclr_ovf = wr_en && (wr_addr == ADR_FCLR) && wr_data[0];

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            fclr_cmp[i] = wr_en && (wr_addr == ADR_FCLR) && wr_data[i+1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= '0;
            mode_q <= WM_NORMAL;
        end else if (ctrl_wr) begin
            cs_q   <= wr_data[2:0];
            mode_q <= wave_mode_e'(wr_data[5:3]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            om_q <= '0;
        end else if (wr_en && (wr_addr == ADR_OMODE)) begin
            om_q <= wr_data[2*NCH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (hi_wr) begin
            hi_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (wr_en && (wr_addr == ADR_CAP_LO)) begin
            cap_q <= {hi_q, wr_data};
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        localparam logic [ADR_W-1:0] A_LO = ADR_W'(int'(ADR_CMP_BASE) + 2 * g);
        logic [REG_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en && (wr_addr == A_LO)) begin
                val_q <= {hi_q, wr_data};
            end
        end
        assign cmp_q[g] = val_q;
    end

    // R9
    hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADR_CNT_HI)) |=> ($stable(cmp_q) && $stable(cap_q)));

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PSC_W = 10,
    parameter int SH_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [2:0]        cs,
    input  logic [7*SH_W-1:0] psc_tbl,
    output logic              tick
);

    localparam int NSEL = 8;

    logic [SH_W-1:0]  tbl_e [NSEL];
    logic [SH_W-1:0]  shift;
    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] mask;

    assign tbl_e[0] = '0;
    for (genvar k = 1; k < NSEL; k++) begin : g_tbl
        assign tbl_e[k] = psc_tbl[(k-1)*SH_W +: SH_W];
    end

    assign shift = tbl_e[cs];
    assign mask  = ~({PSC_W{1'b1}} << shift);
    assign tick  = (cs != 3'd0) && ((psc_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (restart) begin
            psc_q <= '0;
        end else if (cs != 3'd0) begin
            psc_q <= psc_q + PSC_W'(1);
        end
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [2:0]       cs_new,
    input  wave_mode_e       mode,
    input  logic [REG_W-1:0] cmp_a,
    input  logic [REG_W-1:0] cap,
    input  logic             cnt_load,
    input  logic [REG_W-1:0] load_val,
    input  logic             fclr_ovf,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] top,
    output logic             step,
    output logic             ovf_q
);

    run_state_e state_q;
    run_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (restart && (cs_new != 3'd0)) state_d = ST_RUN;
            ST_RUN:  if (restart && (cs_new == 3'd0)) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (mode)
            WM_FAST8:         top = CNT_W'(8'hFF);
            WM_CTC, WM_PWM_A: top = cmp_a[CNT_W-1:0];
            WM_PWM_CAP:       top = cap[CNT_W-1:0];
            default:          top = '1;
        endcase
    end

    assign step    = (state_q == ST_RUN) && tick && !restart && !cnt_load;
    assign cnt_nxt = (cnt_q >= top) ? '0 : cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (restart) begin
                cnt_q <= '0;
            end else if (cnt_load) begin
                cnt_q <= load_val[CNT_W-1:0];
            end else if (step) begin
                cnt_q <= cnt_nxt;
            end
            if (step && (cnt_nxt == top)) begin
                ovf_q <= 1'b1;
            end else if (fclr_ovf) begin
                ovf_q <= 1'b0;
            end
        end
    end

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HALT) && !restart && !cnt_load) |=> $stable(cnt_q));

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (cnt_q >= top)) |=> (cnt_q == '0));

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (cnt_nxt == top)) |=> ovf_q);

    // R8
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R10
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_load && !restart) |=> (cnt_q == $past(load_val[CNT_W-1:0])));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] top,
    input  logic [REG_W-1:0] cmp,
    input  logic [1:0]       om,
    input  logic             fclr,
    output logic             flag_q,
    output logic             pin_q,
    output logic             drive
);

    logic [CNT_W-1:0] cmp_t;
    out_mode_e        om_e;
    logic             fire;
    logic             pin_d;

    assign cmp_t = cmp[CNT_W-1:0];
    assign om_e  = out_mode_e'(om);
    assign fire  = step && (cmp_t != '0) && (cmp_t <= top) && (cnt_nxt == cmp_t);
    assign drive = (om_e != OM_OFF);

    always_comb begin
        pin_d = pin_q;
        if (fire) begin
            unique case (om_e)
                OM_TOGGLE: pin_d = ~pin_q;
                OM_CLEAR:  pin_d = 1'b0;
                OM_SET:    pin_d = 1'b1;
                default:   pin_d = pin_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            pin_q <= pin_d;
            if (fire) begin
                flag_q <= 1'b1;
            end else if (fclr) begin
                flag_q <= 1'b0;
            end
        end
    end

    // R7
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (om_e == OM_TOGGLE)) |=> (pin_q != $past(pin_q)));

    // R7
    set_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (om_e == OM_SET || om_e == OM_CLEAR)) |=> (pin_q == ($past(om_e) == OM_SET)));

    // R6
    zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_t == '0) && !flag_q) |=> !flag_q);

endmodule

// File: rtl/tmr_cmp_top.sv
module tmr_cmp_top
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 3,
    parameter int PSC_W = 10,
    parameter int SH_W  = $clog2(PSC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7*SH_W-1:0] psc_tbl,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_flag,
    output logic [NCH-1:0]    cmp_flag,
    output logic [NCH-1:0]    oc_pin,
    output logic [NCH-1:0]    oc_drive
);

    logic [2:0]                cs_q;
    logic [2:0]                cs_new;
    wave_mode_e                mode_q;
    logic [2*NCH-1:0]          om_q;
    logic [NCH-1:0][REG_W-1:0] cmp_q;
    logic [REG_W-1:0]          cap_q;
    logic                      restart;
    logic                      cnt_load;
    logic [REG_W-1:0]          load_val;
    logic                      fclr_ovf;
    logic [NCH-1:0]            fclr_cmp;
    logic                      tick;
    logic [CNT_W-1:0]          cnt_nxt;
    logic [CNT_W-1:0]          top;
    logic                      step;

    tmr_regs #(.NCH(NCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cs_q     (cs_q),
        .mode_q   (mode_q),
        .om_q     (om_q),
        .cmp_q    (cmp_q),
        .cap_q    (cap_q),
        .restart  (restart),
        .cs_new   (cs_new),
        .cnt_load (cnt_load),
        .load_val (load_val),
        .fclr_ovf (fclr_ovf),
        .fclr_cmp (fclr_cmp)
    );

    tmr_prescale #(.PSC_W(PSC_W), .SH_W(SH_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .cs      (cs_q),
        .psc_tbl (psc_tbl),
        .tick    (tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .cs_new   (cs_new),
        .mode     (mode_q),
        .cmp_a    (cmp_q[0]),
        .cap      (cap_q),
        .cnt_load (cnt_load),
        .load_val (load_val),
        .fclr_ovf (fclr_ovf),
        .cnt_q    (count),
        .cnt_nxt  (cnt_nxt),
        .top      (top),
        .step     (step),
        .ovf_q    (ovf_flag)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_chan #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step),
            .cnt_nxt (cnt_nxt),
            .top     (top),
            .cmp     (cmp_q[g]),
            .om      (om_q[2*g +: 2]),
            .fclr    (fclr_cmp[g]),
            .flag_q  (cmp_flag[g]),
            .pin_q   (oc_pin[g]),
            .drive   (oc_drive[g])
        );
    end

endmodule

// File: tb/sim_tmr_cmp_top.sv
module sim_tmr_cmp_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [27:0] psc_tbl = {4'd2, 4'd1, 4'd10, 4'd8, 4'd6, 4'd3, 4'd0};
    logic [15:0] count;
    logic        ovf_flag;
    logic [2:0]  cmp_flag;
    logic [2:0]  oc_pin;
    logic [2:0]  oc_drive;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tmr_cmp_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .psc_tbl(psc_tbl), .count(count), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
        .oc_pin(oc_pin), .oc_drive(oc_drive)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int shift_of(input logic [2:0] s);
        case (s)
            3'd1: return 0;
            3'd2: return 3;
            3'd3: return 6;
            3'd4: return 8;
            3'd5: return 10;
            3'd6: return 1;
            3'd7: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] top_of(input logic [2:0] md, input logic [15:0] a, input logic [15:0] c);
        case (md)
            3'd1:       return 16'h00FF;
            3'd2, 3'd3: return a;
            3'd4:       return c;
            default:    return 16'hFFFF;
        endcase
    endfunction

    // reference model built from the requirements
    logic [15:0] m_cnt, m_cap, m_top, m_nx;
    logic [15:0] m_cmp [3];
    logic [9:0]  m_psc, m_mask;
    logic [2:0]  m_cs, m_mode;
    logic [5:0]  m_om;
    logic [7:0]  m_hi;
    logic        m_ovf, m_rs, m_ld, m_stp;
    logic [2:0]  m_flg, m_pin;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = '0; m_cap = '0; m_psc = '0; m_cs = '0; m_mode = '0; m_om = '0;
            m_hi = '0; m_ovf = 1'b0; m_flg = '0; m_pin = '0;
            for (int k = 0; k < 3; k++) m_cmp[k] = '0;
        end else begin
            m_top  = top_of(m_mode, m_cmp[0], m_cap);
            m_rs   = wr_en && wr_addr == 4'd0 && (wr_data[2:0] != m_cs || wr_data[5:3] != m_mode);
            m_ld   = wr_en && wr_addr == 4'd2;
            m_mask = ~(10'h3FF << shift_of(m_cs));
            m_stp  = (m_cs != 0) && ((m_psc & m_mask) == m_mask) && !m_rs && !m_ld;
            m_nx   = (m_cnt >= m_top) ? 16'd0 : m_cnt + 16'd1;
            if (wr_en && wr_addr == 4'd12) begin
                if (wr_data[0]) m_ovf = 1'b0;
                for (int k = 0; k < 3; k++) if (wr_data[k+1]) m_flg[k] = 1'b0;
            end
            if (m_stp) begin
                if (m_nx == m_top) m_ovf = 1'b1;
                for (int k = 0; k < 3; k++) begin
                    if (m_cmp[k] != 0 && m_cmp[k] <= m_top && m_nx == m_cmp[k]) begin
                        m_flg[k] = 1'b1;
                        case (m_om[2*k +: 2])
                            2'd1: m_pin[k] = ~m_pin[k];
                            2'd2: m_pin[k] = 1'b0;
                            2'd3: m_pin[k] = 1'b1;
                            default: ;
                        endcase
                    end
                end
            end
            if (m_rs) begin
                m_cnt = '0;
                m_psc = '0;
            end else begin
                if (m_ld) m_cnt = {m_hi, wr_data};
                else if (m_stp) m_cnt = m_nx;
                if (m_cs != 0) m_psc = m_psc + 10'd1;
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd0: begin m_cs = wr_data[2:0]; m_mode = wr_data[5:3]; end
                    4'd1: m_om = wr_data[5:0];
                    4'd3, 4'd5, 4'd7, 4'd9, 4'd11: m_hi = wr_data;
                    4'd4: m_cmp[0] = {m_hi, wr_data};
                    4'd6: m_cmp[1] = {m_hi, wr_data};
                    4'd8: m_cmp[2] = {m_hi, wr_data};
                    4'd10: m_cap = {m_hi, wr_data};
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R4 count", 32'(count), 32'(m_cnt));
            check("R5 overflow flag", 32'(ovf_flag), 32'(m_ovf));
            check("R6 channel flags", 32'(cmp_flag), 32'(m_flg));
            check("R7 pins", 32'(oc_pin), 32'(m_pin));
            check("R7 drive", 32'(oc_drive), 32'({m_om[5:4] != 0, m_om[3:2] != 0, m_om[1:0] != 0}));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [2:0] pick_cs();
        case ($urandom % 6)
            0, 1: return 3'd1;
            2:    return 3'd6;
            3:    return 3'd7;
            4:    return 3'd0;
            default: return 3'd2;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd24681);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1 reset state
        check("R1 count", 32'(count), 0);
        check("R1 flags", 32'({ovf_flag, cmp_flag}), 0);
        check("R1 pins", 32'({oc_pin, oc_drive}), 0);
        // R2 select zero holds
        repeat (5) @(negedge clk);
        check("R2 halted count", 32'(count), 0);
        wr(4'd0, 8'h01);
        check("R8 restart clears", 32'(count), 0);
        repeat (5) @(negedge clk);
        check("R2 divide by one", 32'(count), 5);
        // R8 rewrite same select and mode, upper bits differ
        wr(4'd0, 8'hC1);
        check("R8 no restart", 32'(count), 6);
        wr(4'd0, 8'h02);
        repeat (23) @(negedge clk);
        check("R2 divide by eight early", 32'(count), 2);
        @(negedge clk);
        check("R2 divide by eight", 32'(count), 3);
        wr(4'd0, 8'h00);
        repeat (4) @(negedge clk);
        check("R2 stopped", 32'(count), 0);
        wr(4'd0, 8'h01);
        wr(4'd3, 8'h12);
        check("R9 high byte latched only", 32'(count), 1);
        wr(4'd2, 8'h34);
        check("R10 load", 32'(count), 32'h1234);
        @(negedge clk);
        check("R10 continues", 32'(count), 32'h1235);
        // compare setup: A=5, B=0, C=9 ; pins A toggle, B set, C clear
        wr(4'd5, 8'h00); wr(4'd4, 8'h05);
        wr(4'd7, 8'h00); wr(4'd6, 8'h00);
        wr(4'd9, 8'h00); wr(4'd8, 8'h09);
        wr(4'd1, 8'h2D);
        wr(4'd12, 8'h0F);
        wr(4'd0, 8'h11);
        check("R11 flags cleared", 32'({ovf_flag, cmp_flag}), 0);
        repeat (4) @(negedge clk);
        check("R3 ctc count", 32'(count), 4);
        check("R7 pin before match", 32'(oc_pin), 0);
        @(negedge clk);
        check("R3 ctc reaches top", 32'(count), 5);
        check("R5 overflow at top", 32'(ovf_flag), 1);
        check("R6 channel 0 match", 32'(cmp_flag), 32'b001);
        check("R7 toggle on", 32'(oc_pin), 32'b001);
        check("R7 drive enables", 32'(oc_drive), 32'b111);
        @(negedge clk);
        check("R4 wrap to zero", 32'(count), 0);
        repeat (5) @(negedge clk);
        check("R7 toggle off", 32'(oc_pin), 32'b000);
        check("R6 zero and above top never match", 32'(cmp_flag[2:1]), 0);
        // R11 selective clear
        wr(4'd0, 8'h10);
        wr(4'd12, 8'h01);
        check("R11 overflow cleared", 32'(ovf_flag), 0);
        check("R11 channel flag kept", 32'(cmp_flag), 32'b001);
        wr(4'd12, 8'h02);
        check("R11 channel flag cleared", 32'(cmp_flag), 0);
        // R3 capture-defined top
        wr(4'd11, 8'h00); wr(4'd10, 8'h03);
        wr(4'd0, 8'h21);
        repeat (3) @(negedge clk);
        check("R3 capture top", 32'(count), 3);
        check("R5 overflow capture top", 32'(ovf_flag), 1);
        @(negedge clk);
        check("R4 wrap capture top", 32'(count), 0);
        // R3 eight-bit fast mode
        wr(4'd0, 8'h09);
        wr(4'd12, 8'h0F);
        wr(4'd3, 8'h00);
        wr(4'd2, 8'd250);
        repeat (5) @(negedge clk);
        check("R3 eight-bit top", 32'(count), 255);
        check("R5 overflow eight-bit", 32'(ovf_flag), 1);
        @(negedge clk);
        check("R4 wrap eight-bit", 32'(count), 0);
        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 5 == 0) begin
                logic [3:0] a;
                logic [7:0] d;
                a = 4'($urandom % 13);
                case (a)
                    4'd0: d = {2'($urandom), 3'($urandom), pick_cs()};
                    4'd3, 4'd5, 4'd7, 4'd9, 4'd11: d = ($urandom % 8 == 0) ? 8'hFF : 8'h00;
                    4'd4, 4'd6, 4'd8, 4'd10: d = 8'($urandom % 40);
                    default: d = 8'($urandom);
                endcase
                wr_addr = a;
                wr_data = d;
                wr_en   = 1'b1;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule